// File: doc/BRIEF.md
# Vector Register Hazard Scoreboard

This block sits in the issue stage of a vector sequencer whose instructions can retire in any order. For every architectural vector register, it remembers two things. The first is the identifier of the most recent instruction that writes the register. The second is a bit set that marks every instruction still reading it. Identifiers come from a small pool, and bit `i` of every identifier vector stands for identifier `i`.

On each accepted issue, the block produces three dependency vectors, one each for the first source, the second source and the mask operand. Each vector lists the identifiers that the new instruction must wait for. The block then records the new instruction as a reader of its sources and as the writer of its destination. Register 0 is the mask register, and a masked instruction reads it.

Every cycle, a running vector from the retirement side prunes the records. Because all pending readers are kept, and not only the most recent one, a writer cannot overtake a slow earlier reader.

The issue side follows valid/ready rules. An issue is accepted only in a cycle where `issue_valid_i` and `sched_ready_i` are both high. While ready is low, the request has no effect and may be held. Results come back as a one-cycle `haz_valid_o` pulse, and the vectors hold their value until the next accepted issue.

Top module: `vreg_hazard_sb`

## Requirements
- R1: After reset no register has a recorded reader or writer, `haz_valid_o` is 0, all three vectors are 0, and a first issue reports all-zero vectors.
- R2: An issue is accepted in a cycle where `issue_valid_i` and `sched_ready_i` are both 1. The vectors for it appear, with `haz_valid_o`=1, after the next rising edge. Otherwise `haz_valid_o` is 0 and the vectors keep their value.
- R3: When `use_vs1_i` (or `use_vs2_i`) is 1, `haz_vs1_o` (or `haz_vs2_o`) has the bit of the last still-running writer of that source register set.
- R4: When `masked_i` is 1, the instruction reads register 0. `haz_mask_o` carries the bit of register 0's last running writer, and the instruction is recorded as a reader of register 0.
- R5: When `use_vd_i` is 1, the bits of every running reader of the destination register are set in all three vectors.
- R6: When `use_vd_i` is 1, the bit of the destination register's last running writer is set in all three vectors.
- R7: An identifier whose `running_i` bit is 0 in the issue cycle contributes no bit to any vector, including when it retires in that same cycle.
- R8: A new writer of a register replaces the previous writer record, so later readers see only the newest writer.
- R9: Recording a reader adds its bit and keeps the bits of all other pending readers of that register.
- R10: An unused operand contributes no bit. A request presented while `sched_ready_i` is 0 records nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| issue_valid_i | input | 1 | Issue request valid |
| sched_ready_i | input | 1 | Downstream ready; the issue is accepted when this and valid are high |
| issue_id_i | input | $clog2(NUM_IDS) | Identifier of the issuing instruction |
| use_vs1_i | input | 1 | First source is read |
| vs1_i | input | $clog2(NUM_VREGS) | First source register |
| use_vs2_i | input | 1 | Second source is read |
| vs2_i | input | $clog2(NUM_VREGS) | Second source register |
| use_vd_i | input | 1 | Destination is written |
| vd_i | input | $clog2(NUM_VREGS) | Destination register |
| masked_i | input | 1 | Instruction is masked and reads register 0 |
| running_i | input | NUM_IDS | Bit i high while identifier i is in flight |
| haz_valid_o | output | 1 | One-cycle pulse: vectors belong to the issue accepted at the previous edge |
| haz_vs1_o | output | NUM_IDS | Identifiers the first source must wait for |
| haz_vs2_o | output | NUM_IDS | Identifiers the second source must wait for |
| haz_mask_o | output | NUM_IDS | Identifiers the mask operand must wait for |

## Verification
Each dependency vector is due exactly one rising edge after the edge that accepts the issue. The bench's reference model computes the expected vectors at that accepting edge, from the running vector it drives itself. The outputs are compared at the following falling edge, and again at every later falling edge, so holding and the absence of spurious pulses are also checked. Record updates take effect at the accepting edge. A retirement shows up in an issue presented in the same cycle, because the pruning is combinational ahead of the lookup.

// File: rtl/vhz_pkg.sv
package vhz_pkg;
  localparam int unsigned VHZ_NUM_VREGS = 32;
  localparam int unsigned VHZ_NUM_IDS   = 8;
  localparam int unsigned VHZ_MASK_REG  = 0;
endpackage

// File: rtl/vhz_read_track.sv
module vhz_read_track #(
  parameter int unsigned NUM_VREGS = 32,
  parameter int unsigned NUM_IDS   = 8,
  parameter int unsigned MASK_REG  = 0,
  localparam int unsigned RW = $clog2(NUM_VREGS),
  localparam int unsigned IW = $clog2(NUM_IDS)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_IDS-1:0] running_i,
  input  logic               fire_i,
  input  logic [IW-1:0]      id_i,
  input  logic               use_vs1_i,
  input  logic [RW-1:0]      vs1_i,
  input  logic               use_vs2_i,
  input  logic [RW-1:0]      vs2_i,
  input  logic               masked_i,
  input  logic [RW-1:0]      vd_i,
  output logic [NUM_IDS-1:0] war_o
);
  logic [NUM_VREGS-1:0][NUM_IDS-1:0] rd_q, rd_live;
  logic [NUM_IDS-1:0] id_bit;

  assign id_bit = NUM_IDS'(1) << id_i;

  for (genvar v = 0; v < NUM_VREGS; v++) begin : g_reg
    logic hit;
    assign rd_live[v] = rd_q[v] & running_i;
    assign hit = fire_i && ((use_vs1_i && vs1_i == RW'(v)) ||
                            (use_vs2_i && vs2_i == RW'(v)) ||
                            (masked_i  && v == MASK_REG));
    always_ff @(posedge clk) begin
      if (!rst_n) rd_q[v] <= '0;
      else        rd_q[v] <= rd_live[v] | (hit ? id_bit : '0);
    end
  end

  assign war_o = rd_live[vd_i];
endmodule

// File: rtl/vhz_write_track.sv
module vhz_write_track #(
  parameter int unsigned NUM_VREGS = 32,
  parameter int unsigned NUM_IDS   = 8,
  parameter int unsigned MASK_REG  = 0,
  localparam int unsigned RW = $clog2(NUM_VREGS),
  localparam int unsigned IW = $clog2(NUM_IDS)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_IDS-1:0] running_i,
  input  logic               fire_i,
  input  logic [IW-1:0]      id_i,
  input  logic               use_vd_i,
  input  logic [RW-1:0]      vs1_i,
  input  logic [RW-1:0]      vs2_i,
  input  logic [RW-1:0]      vd_i,
  output logic [NUM_IDS-1:0] wr_vs1_o,
  output logic [NUM_IDS-1:0] wr_vs2_o,
  output logic [NUM_IDS-1:0] wr_mask_o,
  output logic [NUM_IDS-1:0] wr_vd_o
);
  logic [NUM_VREGS-1:0][IW-1:0] wid_q;
  logic [NUM_VREGS-1:0]         wv_q, wv_live;
  logic [NUM_VREGS-1:0][NUM_IDS-1:0] owner;

  for (genvar v = 0; v < NUM_VREGS; v++) begin : g_reg
    assign wv_live[v] = wv_q[v] && running_i[wid_q[v]];
    assign owner[v]   = wv_live[v] ? (NUM_IDS'(1) << wid_q[v]) : '0;
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        wv_q[v]  <= 1'b0;
        wid_q[v] <= '0;
      end else if (fire_i && use_vd_i && vd_i == RW'(v)) begin
        wv_q[v]  <= 1'b1;
        wid_q[v] <= id_i;
      end else begin
        wv_q[v]  <= wv_live[v];
      end
    end
  end

  assign wr_vs1_o  = owner[vs1_i];
  assign wr_vs2_o  = owner[vs2_i];
  assign wr_mask_o = owner[MASK_REG];
  assign wr_vd_o   = owner[vd_i];
endmodule

// File: rtl/vreg_hazard_sb.sv
module vreg_hazard_sb
  import vhz_pkg::*;
#(
  parameter int unsigned NUM_VREGS = VHZ_NUM_VREGS,
  parameter int unsigned NUM_IDS   = VHZ_NUM_IDS,
  parameter int unsigned MASK_REG  = VHZ_MASK_REG,
  localparam int unsigned RW = $clog2(NUM_VREGS),
  localparam int unsigned IW = $clog2(NUM_IDS)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               issue_valid_i,
  input  logic               sched_ready_i,
  input  logic [IW-1:0]      issue_id_i,
  input  logic               use_vs1_i,
  input  logic [RW-1:0]      vs1_i,
  input  logic               use_vs2_i,
  input  logic [RW-1:0]      vs2_i,
  input  logic               use_vd_i,
  input  logic [RW-1:0]      vd_i,
  input  logic               masked_i,
  input  logic [NUM_IDS-1:0] running_i,
  output logic               haz_valid_o,
  output logic [NUM_IDS-1:0] haz_vs1_o,
  output logic [NUM_IDS-1:0] haz_vs2_o,
  output logic [NUM_IDS-1:0] haz_mask_o
);
  logic fire;
  logic [NUM_IDS-1:0] war, wr_vs1, wr_vs2, wr_mask, wr_vd, dst_dep;
  logic [NUM_IDS-1:0] dep_vs1, dep_vs2, dep_mask;

  assign fire = issue_valid_i && sched_ready_i;

  vhz_read_track #(.NUM_VREGS(NUM_VREGS), .NUM_IDS(NUM_IDS), .MASK_REG(MASK_REG)) u_rd (
    .clk(clk), .rst_n(rst_n), .running_i(running_i), .fire_i(fire), .id_i(issue_id_i),
    .use_vs1_i(use_vs1_i), .vs1_i(vs1_i), .use_vs2_i(use_vs2_i), .vs2_i(vs2_i),
    .masked_i(masked_i), .vd_i(vd_i), .war_o(war)
  );

  vhz_write_track #(.NUM_VREGS(NUM_VREGS), .NUM_IDS(NUM_IDS), .MASK_REG(MASK_REG)) u_wr (
    .clk(clk), .rst_n(rst_n), .running_i(running_i), .fire_i(fire), .id_i(issue_id_i),
    .use_vd_i(use_vd_i), .vs1_i(vs1_i), .vs2_i(vs2_i), .vd_i(vd_i),
    .wr_vs1_o(wr_vs1), .wr_vs2_o(wr_vs2), .wr_mask_o(wr_mask), .wr_vd_o(wr_vd)
  );

  always_comb begin
    dst_dep  = use_vd_i ? (war | wr_vd) : '0;
    dep_vs1  = (use_vs1_i ? wr_vs1  : '0) | dst_dep;
    dep_vs2  = (use_vs2_i ? wr_vs2  : '0) | dst_dep;
    dep_mask = (masked_i  ? wr_mask : '0) | dst_dep;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      haz_valid_o <= 1'b0;
      haz_vs1_o   <= '0;
      haz_vs2_o   <= '0;
      haz_mask_o  <= '0;
    end else begin
      haz_valid_o <= fire;
      if (fire) begin
        haz_vs1_o  <= dep_vs1;
        haz_vs2_o  <= dep_vs2;
        haz_mask_o <= dep_mask;
      end
    end
  end
endmodule

// File: rtl/vreg_hazard_sb_chk.sv
module vreg_hazard_sb_chk #(
  parameter int unsigned NUM_IDS = 8
) (
  input logic               clk,
  input logic               rst_n,
  input logic               issue_valid_i,
  input logic               sched_ready_i,
  input logic               use_vs1_i,
  input logic               use_vs2_i,
  input logic               use_vd_i,
  input logic               masked_i,
  input logic [NUM_IDS-1:0] running_i,
  input logic               haz_valid_o,
  input logic [NUM_IDS-1:0] haz_vs1_o,
  input logic [NUM_IDS-1:0] haz_vs2_o,
  input logic [NUM_IDS-1:0] haz_mask_o
);
  logic fire;
  assign fire = issue_valid_i && sched_ready_i;

  a_r2_result_after_accept: assert property (@(posedge clk) disable iff (!rst_n)
    fire |=> haz_valid_o);

  a_r2_hold_when_idle: assert property (@(posedge clk) disable iff (!rst_n)
    !fire |=> (!haz_valid_o && $stable(haz_vs1_o) && $stable(haz_vs2_o) && $stable(haz_mask_o)));

  a_r7_only_running_ids: assert property (@(posedge clk) disable iff (!rst_n)
    haz_valid_o |-> (((haz_vs1_o | haz_vs2_o | haz_mask_o) & ~$past(running_i)) == '0));

  a_r5_dest_deps_shared: assert property (@(posedge clk) disable iff (!rst_n)
    (fire && !use_vs1_i && !use_vs2_i && !masked_i) |=>
      (haz_vs1_o == haz_vs2_o && haz_vs2_o == haz_mask_o));

  a_r10_no_operands_no_deps: assert property (@(posedge clk) disable iff (!rst_n)
    (fire && !use_vs1_i && !use_vs2_i && !masked_i && !use_vd_i) |=>
      (haz_vs1_o == '0 && haz_vs2_o == '0 && haz_mask_o == '0));
endmodule

bind vreg_hazard_sb vreg_hazard_sb_chk #(.NUM_IDS(NUM_IDS)) u_chk (
  .clk(clk), .rst_n(rst_n), .issue_valid_i(issue_valid_i), .sched_ready_i(sched_ready_i),
  .use_vs1_i(use_vs1_i), .use_vs2_i(use_vs2_i), .use_vd_i(use_vd_i), .masked_i(masked_i),
  .running_i(running_i), .haz_valid_o(haz_valid_o), .haz_vs1_o(haz_vs1_o),
  .haz_vs2_o(haz_vs2_o), .haz_mask_o(haz_mask_o)
);

// File: tb/test_vreg_hazard_sb.sv
`timescale 1ns/1ps
module test_vreg_hazard_sb;
  localparam int NV = 32;
  localparam int NI = 8;
  localparam int RW = $clog2(NV);
  localparam int IW = $clog2(NI);

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic issue_valid = 1'b0, sched_ready = 1'b0;
  logic [IW-1:0] issue_id = '0;
  logic use_vs1 = 1'b0, use_vs2 = 1'b0, use_vd = 1'b0, masked = 1'b0;
  logic [RW-1:0] vs1 = '0, vs2 = '0, vd = '0;
  logic [NI-1:0] run = '0;
  logic haz_valid;
  logic [NI-1:0] haz_vs1, haz_vs2, haz_mask;

  always #2 clk = ~clk;

  vreg_hazard_sb i_vreg_hazard_sb (
    .clk(clk), .rst_n(rst_n), .issue_valid_i(issue_valid), .sched_ready_i(sched_ready),
    .issue_id_i(issue_id), .use_vs1_i(use_vs1), .vs1_i(vs1), .use_vs2_i(use_vs2),
    .vs2_i(vs2), .use_vd_i(use_vd), .vd_i(vd), .masked_i(masked), .running_i(run),
    .haz_valid_o(haz_valid), .haz_vs1_o(haz_vs1), .haz_vs2_o(haz_vs2), .haz_mask_o(haz_mask)
  );

  int checks = 0, fails = 0;
  string cur_tag = "R1", exp_tag = "R1";

  // Reference model: readers kept as id lists, writer as an int (-1 = none)
  int rdq[NV][$];
  int wr[NV];
  int keep[$];
  logic exp_valid = 1'b0;
  logic [NI-1:0] e_vs1 = '0, e_vs2 = '0, e_mask = '0;

  function automatic logic [NI-1:0] readers_of(int r);
    logic [NI-1:0] b = '0;
    for (int k = 0; k < rdq[r].size(); k++) b[rdq[r][k]] = 1'b1;
    return b;
  endfunction

  function automatic logic [NI-1:0] writer_of(int r);
    logic [NI-1:0] b = '0;
    if (wr[r] >= 0) b[wr[r]] = 1'b1;
    return b;
  endfunction

  task automatic add_reader(int r, int id);
    for (int k = 0; k < rdq[r].size(); k++) if (rdq[r][k] == id) return;
    rdq[r].push_back(id);
  endtask

  always @(posedge clk) begin
    if (!rst_n) begin
      for (int v = 0; v < NV; v++) begin rdq[v] = {}; wr[v] = -1; end
      exp_valid = 1'b0; e_vs1 = '0; e_vs2 = '0; e_mask = '0;
    end else begin
      for (int v = 0; v < NV; v++) begin
        keep = {};
        for (int k = 0; k < rdq[v].size(); k++) if (run[rdq[v][k]]) keep.push_back(rdq[v][k]);
        rdq[v] = keep;
        if (wr[v] >= 0 && !run[wr[v]]) wr[v] = -1;
      end
      exp_valid = issue_valid && sched_ready;
      if (exp_valid) begin
        logic [NI-1:0] dst;
        dst    = use_vd ? (readers_of(int'(vd)) | writer_of(int'(vd))) : '0;
        e_vs1  = (use_vs1 ? writer_of(int'(vs1)) : '0) | dst;
        e_vs2  = (use_vs2 ? writer_of(int'(vs2)) : '0) | dst;
        e_mask = (masked ? writer_of(0) : '0) | dst;
        exp_tag = cur_tag;
        if (use_vs1) add_reader(int'(vs1), int'(issue_id));
        if (use_vs2) add_reader(int'(vs2), int'(issue_id));
        if (masked)  add_reader(0, int'(issue_id));
        if (use_vd)  wr[int'(vd)] = int'(issue_id);
      end
    end
  end

  task automatic chk(string tag, string what, logic [NI-1:0] act, logic [NI-1:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s actual=%b expected=%b", tag, what, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n) begin
      chk("R2", "haz_valid", NI'(haz_valid), NI'(exp_valid));
      chk(exp_tag, "haz_vs1", haz_vs1, e_vs1);
      chk(exp_tag, "haz_vs2", haz_vs2, e_vs2);
      chk(exp_tag, "haz_mask", haz_mask, e_mask);
    end
  end

  // Called right after a falling edge; drives one request for one cycle.
  task automatic issue(string tag, int id, bit u1, int s1, bit u2, int s2,
                       bit ud, int d, bit m, bit rdy);
    cur_tag = tag;
    issue_id = IW'(id); use_vs1 = u1; vs1 = RW'(s1); use_vs2 = u2; vs2 = RW'(s2);
    use_vd = ud; vd = RW'(d); masked = m; issue_valid = 1'b1; sched_ready = rdy;
    @(negedge clk);
    issue_valid = 1'b0; sched_ready = 1'b0;
    if (rdy) run[id] = 1'b1;
  endtask

  bit done = 1'b0;
  initial begin
    #200000;
    if (!done) begin
      fails++; checks++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1: reset state (also compared by the per-cycle monitor)
    chk("R1", "reset valid", NI'(haz_valid), '0);
    chk("R1", "reset vectors", haz_vs1 | haz_vs2 | haz_mask, '0);
    issue("R1", 0, 1, 2, 1, 4, 0, 0, 0, 1);       // reads v2,v4: nothing recorded yet
    // R3: RAW on each source
    issue("R3", 1, 0, 0, 0, 0, 1, 6, 0, 1);       // id1 writes v6
    issue("R3", 2, 1, 6, 0, 0, 0, 0, 0, 1);       // vs1 waits id1
    issue("R3", 3, 0, 0, 1, 6, 0, 0, 0, 1);       // vs2 waits id1
    // R9/R5: several readers of v2, then a writer waits for all of them
    issue("R9", 4, 1, 4, 1, 2, 0, 0, 0, 1);
    issue("R9", 5, 1, 2, 0, 0, 0, 0, 0, 1);
    issue("R5", 6, 0, 0, 0, 0, 1, 2, 0, 1);       // expect {0,4,5} in all three
    // R6/R7: readers retire, same-cycle retirement of id5
    run[0] = 0; run[2] = 0; run[3] = 0; run[4] = 0;
    @(negedge clk);
    run[5] = 0;
    issue("R6", 0, 0, 0, 0, 0, 1, 2, 0, 1);       // only WAW on id6
    // R8: newest writer replaces id6
    issue("R8", 2, 1, 2, 0, 0, 0, 0, 0, 1);       // waits id0 only
    // R4: mask register writer then masked reader, then writer of mask reg
    issue("R4", 4, 0, 0, 0, 0, 1, 0, 0, 1);
    issue("R4", 3, 1, 8, 1, 9, 0, 0, 1, 1);       // haz_mask = id4
    issue("R4", 5, 0, 0, 0, 0, 1, 0, 0, 1);       // {3,4}
    // R10: request without ready is ignored; unused operands give nothing
    issue("R10", 7, 0, 0, 0, 0, 1, 2, 0, 0);
    issue("R10", 7, 0, 0, 0, 0, 1, 2, 0, 0);
    issue("R10", 7, 1, 2, 0, 6, 0, 2, 0, 1);      // waits id0 only; vs2 unused
    // R7: retire a writer in the issue cycle
    run[0] = 0;
    issue("R7", 1, 1, 2, 0, 0, 0, 0, 0, 1);       // nothing
    // Randomised phase against the model
    for (int it = 0; it < 600; it++) begin
      int pick;
      for (int i = 0; i < NI; i++) if (run[i] && ($urandom % 4 == 0)) run[i] = 1'b0;
      pick = -1;
      for (int i = 0; i < NI; i++) if (!run[i] && pick < 0 && ($urandom % 2 == 0)) pick = i;
      if (pick < 0) @(negedge clk);
      else issue("R9", pick, 1'($urandom), int'($urandom % 6), 1'($urandom),
                 int'($urandom % 6), 1'($urandom), int'($urandom % 6),
                 1'($urandom), ($urandom % 4) != 0);
    end
    repeat (2) @(negedge clk);
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule